// File: doc/BRIEF.md
# Transfer-Group Buffer Sequencer

This block feeds an SPI shift-register kernel from a small buffer RAM, one word at a time. The buffer entries are split into transfer groups. Each group owns a contiguous range of entries that begins at its start pointer and ends one entry below the start pointer of the next group. The last group runs to the top of the RAM. A group becomes pending when its trigger input pulses. When the sequencer is idle it takes the pending group with the lowest index and walks that group's entries in ascending order.

Each entry holds a data word and a ready flag. The sequencer reads an entry through a RAM port that it shares with a host bus. If the ready flag is set, it captures the word into a holding register and hands it to the kernel on the kernel's request. In master mode it then fetches the following entry at once, so the next word is waiting before the kernel needs it. In slave mode it fetches the next word only after the receive side has stored its data and a fresh chip-select assertion arrives. Once the last entry of a group has been handed over, the group's pending flag is cleared.

Top module: `tgs_sequencer`

## Requirements
- R1: After reset no group is pending and `txLoad` stays low until a trigger arrives.
- R2: A group is serviced only after a pulse on its bit of `grpTrig`. Group g covers the entries from its start pointer up to one below the start pointer of group g+1, and the last group covers up to entry DEPTH-1. Its entries are handed out in ascending index order, and each handoff carries the group number on `txGrp` and the entry index on `txIdx`.
- R3: When the sequencer is idle, the pending group with the lowest index is chosen. A group that is in service is never pre-empted by a trigger for another group.
- R4: Bit DATA_W of an entry is its ready flag and bits DATA_W-1:0 are its data. An entry whose ready flag is 0 is read again every few cycles and is never handed out. Entries after it wait until the host makes it ready.
- R5: The host bus always wins the RAM port, and the sequencer waits while the host holds it. A host read returns the addressed entry on `hostRdata` one cycle after the request. A host write takes effect for later reads by either side.
- R6: With `slaveMode` low and `kernelReq` held high, consecutive handoffs within a group are exactly 3 cycles apart. `txLoad` rises in the same cycle as `kernelReq` when a word is already held.
- R7: With `slaveMode` high, after a handoff the next entry is fetched only after a `rxStored` pulse followed by a rising edge of `csActive`. A chip-select that is already high, or that rises before `rxStored`, does not count.
- R8: After the last entry of a group is handed out, that group issues no further handoffs until it is triggered again. A new trigger repeats the whole group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpTrig | input | NUM_GROUPS | One-cycle trigger pulse per group |
| grpStart | input | NUM_GROUPS*ADDR_W | Start pointer per group, group g at bits g*ADDR_W and up, ascending by group |
| slaveMode | input | 1 | 1 selects slave-mode gating of fetches |
| kernelReq | input | 1 | Kernel is ready to take a word |
| rxStored | input | 1 | Pulse: receive data of the last word has been stored |
| csActive | input | 1 | Chip-select active level (slave mode) |
| hostReq | input | 1 | Host RAM access request |
| hostWe | input | 1 | Host write enable |
| hostAddr | input | ADDR_W | Host RAM address |
| hostWdata | input | DATA_W+1 | Host write entry {ready, data} |
| hostRdata | output | DATA_W+1 | RAM read data, valid the cycle after a host read |
| txLoad | output | 1 | Word handed to the shift register this cycle |
| txData | output | DATA_W | Handed-over word |
| txGrp | output | GRP_W | Group of the handed-over word |
| txIdx | output | ADDR_W | Buffer index of the handed-over word |

## Verification
The hardest situations to reach from the ports are the stalled fetch loops. In one, the host holds the RAM port on every cycle. In another, an entry is not ready and the host rewrites it while the sequencer keeps retrying. The bench gets there by sweeping host reads over the whole RAM while a group is pending. It also clears one entry's ready flag before triggering that entry's group and rewrites the entry later. The slave-mode gate is reached by raising chip-select too early, before the receive pulse, and then toggling it, so that only a true rising edge after storage releases the next word. The trigger masks are swept over all 15 combinations, and the expected handoff order and spacing are computed from the start pointers.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_HOLD,
    ST_SLV_RX,
    ST_SLV_CS
  } seqState_t;

  typedef struct packed {
    logic startGrp;  // load pointer from the selected group's start
    logic fetching;  // RAM read of the current pointer requested
    logic capture;   // latch read entry into the holding register
    logic advance;   // step pointer to the next entry
  } seqStrobe_t;

endpackage

// File: rtl/tgs_arbiter.sv
module tgs_arbiter #(
  parameter int ADDR_W  = 4,
  parameter int ENTRY_W = 17
) (
  input  logic               hostReq,
  input  logic               hostWe,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [ENTRY_W-1:0] hostWdata,
  input  logic               seqReq,
  input  logic [ADDR_W-1:0]  seqAddr,
  output logic               seqGrant,
  output logic               ramEn,
  output logic               ramWe,
  output logic [ADDR_W-1:0]  ramAddr,
  output logic [ENTRY_W-1:0] ramWdata
);

  // Host has fixed precedence; the sequencer only gets a free port.
  always_comb begin
    seqGrant = seqReq && !hostReq;
    ramEn    = hostReq || seqReq;
    ramWe    = hostReq && hostWe;
    ramAddr  = hostReq ? hostAddr : seqAddr;
    ramWdata = hostWdata;
  end

endmodule

// File: rtl/tgs_ram.sv
module tgs_ram #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 17,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               en,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] rdata
);

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/tgs_datapath.sv
module tgs_datapath import tgs_pkg::*; #(
  parameter int NUM_GROUPS = 4,
  parameter int DEPTH      = 16,
  parameter int DATA_W     = 16,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ENTRY_W   = DATA_W + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strb,
  input  logic [GRP_W-1:0]             selGrp,
  input  logic [NUM_GROUPS*ADDR_W-1:0] grpStart,
  input  logic [ENTRY_W-1:0]           ramRdata,
  output logic [ADDR_W-1:0]            ptr,
  output logic [GRP_W-1:0]             curGrp,
  output logic                         entryReady,
  output logic                         holdLast,
  output logic [DATA_W-1:0]            holdData,
  output logic [ADDR_W-1:0]            holdIdx
);

  logic [ADDR_W-1:0] startArr [NUM_GROUPS];
  logic [ADDR_W-1:0] endArr   [NUM_GROUPS];
  logic              ptrIsLast;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : gen_bounds
      assign startArr[g] = grpStart[g*ADDR_W +: ADDR_W];
      if (g == NUM_GROUPS - 1) begin : gen_top
        assign endArr[g] = ADDR_W'(DEPTH - 1);
      end else begin : gen_mid
        assign endArr[g] = grpStart[(g+1)*ADDR_W +: ADDR_W] - ADDR_W'(1);
      end
    end
  endgenerate

  assign ptrIsLast  = (ptr == endArr[curGrp]);
  assign entryReady = ramRdata[DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      curGrp   <= '0;
      holdLast <= 1'b0;
      holdData <= '0;
      holdIdx  <= '0;
    end else begin
      if (strb.startGrp) begin
        ptr    <= startArr[selGrp];
        curGrp <= selGrp;
      end else if (strb.advance) begin
        ptr <= ptr + ADDR_W'(1);
      end
      if (strb.capture) begin
        holdData <= ramRdata[DATA_W-1:0];
        holdIdx  <= ptr;
        holdLast <= ptrIsLast;
      end
    end
  end

  // Every RAM fetch must address an entry of the group in service.
  assert_ptr_in_group_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetching |-> (ptr >= startArr[curGrp] && ptr <= endArr[curGrp]));

endmodule

// File: rtl/tgs_ctrl.sv
module tgs_ctrl import tgs_pkg::*; #(
  parameter int NUM_GROUPS = 4,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_GROUPS-1:0] grpTrig,
  input  logic                  slaveMode,
  input  logic                  kernelReq,
  input  logic                  rxStored,
  input  logic                  csActive,
  input  logic                  hostReq,
  input  logic                  seqGrant,
  input  logic                  entryReady,
  input  logic                  holdLast,
  input  logic [GRP_W-1:0]      curGrp,
  output seqStrobe_t            strb,
  output logic [GRP_W-1:0]      selGrp,
  output logic                  seqReq,
  output logic                  txLoad
);

  seqState_t             state, nxtState;
  logic [NUM_GROUPS-1:0] pending, clrMask;
  logic                  csPrev, csRise, anyPending;

  assign csRise     = csActive && !csPrev;
  assign anyPending = |pending;

  // Fixed priority: lowest index wins, so scan downwards.
  always_comb begin
    selGrp = '0;
    for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
      if (pending[i]) selGrp = GRP_W'(i);
    end
  end

  always_comb begin
    nxtState = state;
    strb     = '0;
    seqReq   = 1'b0;
    txLoad   = 1'b0;
    clrMask  = '0;
    unique case (state)
      ST_IDLE: begin
        if (anyPending) begin
          strb.startGrp = 1'b1;
          nxtState      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        seqReq        = 1'b1;
        strb.fetching = 1'b1;
        if (seqGrant) nxtState = ST_CHECK;
      end
      ST_CHECK: begin
        if (entryReady) begin
          strb.capture = 1'b1;
          nxtState     = ST_HOLD;
        end else begin
          nxtState = ST_FETCH;
        end
      end
      ST_HOLD: begin
        if (kernelReq) begin
          txLoad = 1'b1;
          if (holdLast) begin
            clrMask[curGrp] = 1'b1;
            nxtState        = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            nxtState     = slaveMode ? ST_SLV_RX : ST_FETCH;
          end
        end
      end
      ST_SLV_RX: if (rxStored) nxtState = ST_SLV_CS;
      ST_SLV_CS: if (csRise)   nxtState = ST_FETCH;
      default:   nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= '0;
      csPrev  <= 1'b0;
    end else begin
      state   <= nxtState;
      pending <= (pending & ~clrMask) | grpTrig;
      csPrev  <= csActive;
    end
  end

  assert_idle_no_trigger_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && pending == '0) |=> state == ST_IDLE);

  assert_host_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH && hostReq) |=> state == ST_FETCH);

  assert_refetch_not_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !entryReady) |=> state == ST_FETCH);

  assert_master_prefetch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && !holdLast && !slaveMode) |=> state == ST_FETCH);

  assert_slave_cs_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLV_CS && !(csActive && !csPrev)) |=> state == ST_SLV_CS);

  assert_clear_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && holdLast && !grpTrig[curGrp]) |=> !pending[$past(curGrp)]);

endmodule

// File: rtl/tgs_sequencer.sv
module tgs_sequencer import tgs_pkg::*; #(
  parameter int NUM_GROUPS = 4,
  parameter int DEPTH      = 16,
  parameter int DATA_W     = 16,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ENTRY_W   = DATA_W + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_GROUPS-1:0]        grpTrig,
  input  logic [NUM_GROUPS*ADDR_W-1:0] grpStart,
  input  logic                         slaveMode,
  input  logic                         kernelReq,
  input  logic                         rxStored,
  input  logic                         csActive,
  input  logic                         hostReq,
  input  logic                         hostWe,
  input  logic [ADDR_W-1:0]            hostAddr,
  input  logic [ENTRY_W-1:0]           hostWdata,
  output logic [ENTRY_W-1:0]           hostRdata,
  output logic                         txLoad,
  output logic [DATA_W-1:0]            txData,
  output logic [GRP_W-1:0]             txGrp,
  output logic [ADDR_W-1:0]            txIdx
);

  seqStrobe_t         strb;
  logic [GRP_W-1:0]   selGrp, curGrp;
  logic               seqReq, seqGrant, entryReady, holdLast;
  logic [ADDR_W-1:0]  ptr, ramAddr;
  logic               ramEn, ramWe;
  logic [ENTRY_W-1:0] ramWdata, ramRdata;

  tgs_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .grpTrig(grpTrig), .slaveMode(slaveMode),
    .kernelReq(kernelReq), .rxStored(rxStored), .csActive(csActive),
    .hostReq(hostReq), .seqGrant(seqGrant), .entryReady(entryReady),
    .holdLast(holdLast), .curGrp(curGrp), .strb(strb), .selGrp(selGrp),
    .seqReq(seqReq), .txLoad(txLoad)
  );

  tgs_datapath #(.NUM_GROUPS(NUM_GROUPS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .selGrp(selGrp), .grpStart(grpStart),
    .ramRdata(ramRdata), .ptr(ptr), .curGrp(curGrp), .entryReady(entryReady),
    .holdLast(holdLast), .holdData(txData), .holdIdx(txIdx)
  );

  tgs_arbiter #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_arb (
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .seqReq(seqReq), .seqAddr(ptr), .seqGrant(seqGrant), .ramEn(ramEn),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata)
  );

  tgs_ram #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_ram (
    .clk(clk), .en(ramEn), .we(ramWe), .addr(ramAddr), .wdata(ramWdata), .rdata(ramRdata)
  );

  assign hostRdata = ramRdata;
  assign txGrp     = curGrp;

endmodule

// File: tb/tgs_sequencer_tb.sv
module tgs_sequencer_tb;

  localparam int NG = 4;
  localparam int DEPTH = 16;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int ST [NG] = '{0, 3, 7, 12};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NG-1:0] grpTrig = '0;
  logic [NG*AW-1:0] grpStart = {4'd12, 4'd7, 4'd3, 4'd0};
  logic slaveMode = 1'b0, kernelReq = 1'b0, rxStored = 1'b0, csActive = 1'b0;
  logic hostReq = 1'b0, hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW:0] hostWdata = '0;
  logic [DW:0] hostRdata;
  logic txLoad;
  logic [DW-1:0] txData;
  logic [1:0] txGrp;
  logic [AW-1:0] txIdx;

  tgs_sequencer u_dut (
    .clk(clk), .rstN(rstN), .grpTrig(grpTrig), .grpStart(grpStart),
    .slaveMode(slaveMode), .kernelReq(kernelReq), .rxStored(rxStored),
    .csActive(csActive), .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .txLoad(txLoad),
    .txData(txData), .txGrp(txGrp), .txIdx(txIdx)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] shadow [DEPTH];
  int logCount = 0;
  int logGrp [64], logIdx [64], logCyc [64];
  logic [DW-1:0] logData [64];
  int expN = 0;
  int expGrp [64], expIdx [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && txLoad) begin
      if (logCount < 64) begin
        logGrp[logCount]  = int'(txGrp);
        logIdx[logCount]  = int'(txIdx);
        logData[logCount] = txData;
        logCyc[logCount]  = cyc;
      end
      logCount = logCount + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] dataOf(int idx);
    return 16'h5A00 ^ 16'(idx * 16'h0111);
  endfunction

  function automatic int endOf(int g);
    return (g == NG - 1) ? DEPTH - 1 : ST[g+1] - 1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic hostWrite(int addr, logic rdy, logic [DW-1:0] d);
    @(posedge clk); #2;
    hostReq = 1; hostWe = 1; hostAddr = AW'(addr); hostWdata = {rdy, d};
    @(posedge clk); #2;
    hostReq = 0; hostWe = 0;
    shadow[addr] = d;
  endtask

  task automatic trigger(logic [NG-1:0] m);
    @(posedge clk); #2;
    grpTrig = m;
    @(posedge clk); #2;
    grpTrig = '0;
  endtask

  task automatic addGroup(int g);
    for (int i = ST[g]; i <= endOf(g); i++) begin
      expGrp[expN] = g; expIdx[expN] = i; expN = expN + 1;
    end
  endtask

  task automatic clearLog();
    logCount = 0; expN = 0;
  endtask

  task automatic compareLog(string req);
    check(logCount == expN, req, "handoff count", logCount, expN);
    for (int i = 0; i < expN && i < logCount; i++) begin
      check(logGrp[i] == expGrp[i], req, "group", logGrp[i], expGrp[i]);
      check(logIdx[i] == expIdx[i], req, "index", logIdx[i], expIdx[i]);
      check(logData[i] == shadow[expIdx[i]], req, "data",
            int'(logData[i]), int'(shadow[expIdx[i]]));
    end
  endtask

  initial begin
    tick(5);
    // R1: reset state, nothing handed out
    check(txLoad == 1'b0, "R1", "txLoad in reset", int'(txLoad), 0);
    rstN = 1;
    kernelReq = 1;
    for (int a = 0; a < DEPTH; a++) hostWrite(a, 1'b1, dataOf(a));
    tick(10);
    check(logCount == 0, "R1", "loads without trigger", logCount, 0);

    // R5: host reads win the port; sweep all addresses while group 0 pending
    clearLog();
    @(posedge clk); #2; grpTrig = 4'b0001; hostReq = 1; hostWe = 0; hostAddr = 0;
    @(posedge clk); #2; grpTrig = '0;
    for (int a = 1; a <= DEPTH; a++) begin
      check(hostRdata == {1'b1, shadow[a-1]}, "R5", "host read data",
            int'(hostRdata[DW-1:0]), int'(shadow[a-1]));
      hostAddr = AW'(a % DEPTH);
      @(posedge clk); #2;
    end
    check(logCount == 0, "R5", "sequencer starved loads", logCount, 0);
    hostReq = 0;
    tick(30);
    addGroup(0);
    compareLog("R5");

    // R2, R8: each group alone, then retrigger the same group
    for (int g = 0; g < NG; g++) begin
      clearLog();
      trigger(4'(1 << g));
      tick(60);
      addGroup(g);
      compareLog("R2");
      tick(20);
      check(logCount == expN, "R8", "no loads after last", logCount, expN);
      clearLog();
      trigger(4'(1 << g));
      tick(60);
      addGroup(g);
      compareLog("R8");
    end

    // R3, R6: sweep all trigger masks; ascending group order, 3-cycle spacing
    for (int m = 1; m < 16; m++) begin
      clearLog();
      trigger(4'(m));
      tick(100);
      for (int g = 0; g < NG; g++) if (m[g]) addGroup(g);
      compareLog("R3");
      for (int i = 1; i < logCount && i < 64; i++) begin
        if (logGrp[i] == logGrp[i-1])
          check(logCyc[i] - logCyc[i-1] == 3, "R6", "prefetch spacing",
                logCyc[i] - logCyc[i-1], 3);
      end
    end

    // R3: no pre-emption of a group in service
    clearLog();
    trigger(4'b0100);
    tick(4);
    trigger(4'b0001);
    tick(80);
    addGroup(2); addGroup(0);
    compareLog("R3");

    // R4: entry 4 not ready stalls group 1 until the host fixes it
    hostWrite(4, 1'b0, 16'h1234);
    clearLog();
    trigger(4'b0010);
    tick(40);
    check(logCount == 1, "R4", "loads before not-ready entry", logCount, 1);
    hostWrite(4, 1'b1, 16'hBEEF);
    tick(40);
    addGroup(1);
    compareLog("R4");

    // R7: slave mode gating on receive storage and a chip-select rising edge
    slaveMode = 1;
    clearLog();
    trigger(4'b1000);
    tick(20);
    check(logCount == 1, "R7", "first slave word", logCount, 1);
    for (int k = 1; k < 4; k++) begin
      csActive = 1;           // early chip-select, before storage: ignored
      tick(10);
      rxStored = 1; tick(1); rxStored = 0;
      tick(15);
      check(logCount == k, "R7", "held with cs already high", logCount, k);
      csActive = 0; tick(2);
      csActive = 1; tick(10);
      check(logCount == k + 1, "R7", "released by cs edge", logCount, k + 1);
      csActive = 0;
    end
    addGroup(3);
    compareLog("R7");
    slaveMode = 0;

    // R6: same-cycle handoff when kernel asks for an already held word
    kernelReq = 0;
    clearLog();
    trigger(4'b0001);
    tick(10);
    check(logCount == 0, "R6", "no load without request", logCount, 0);
    @(negedge clk); kernelReq = 1; #1;
    check(txLoad == 1'b1, "R6", "same-cycle handoff", int'(txLoad), 1);
    tick(20);
    addGroup(0);
    compareLog("R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule